// File: doc/BRIEF.md
# MSI vector entry P/Q dispatcher

This block processes one interrupt source trigger at a time. From a table base, a table length, an enable flag and an entry-size selector it forms the address of that source's vector entry in memory. It fetches the 64-bit entry over a request/acknowledge memory port and decodes the routing server, the priority, the generation and the two state bits P (pending) and Q (queued). From these bits and the priority it picks one of three outcomes: present the interrupt and set P, set Q only, or drop the trigger. The chosen state change is written back to memory as a single byte.

Interrupt state lives entirely in the in-memory table, so the block holds no per-source storage. A priority of 0xFF masks the source: a trigger on a masked idle source is recorded in Q rather than delivered. A force input makes the block treat the state as idle, which is how a rejected interrupt is replayed. When a delivery is made, the presenter receives the server number, the global source number and the priority. The global source number is the local number plus a configured offset.

Top module: `msi_pq_dispatch`

## Requirements
- R1: After reset, `busy`, `done`, `mem_req` and `pres_valid` are low.
- R2: If `tbl_en` is low when a trigger is accepted, the block makes no memory request and finishes with `done_code` 3 (rejected).
- R3: If the trigger source is greater than or equal to `tbl_len`, the block makes no memory request and finishes with `done_code` 3. A source of `tbl_len`-1 is processed normally.
- R4: The entry read address is `tbl_base` with its low 4 bits cleared, plus the source times 128 when `big_entry` is 1, or plus the source times 16 when it is 0.
- R5: Read data lane k (`mem_rdata[8k+7:8k]`) holds the byte at entry offset k, and the entry is assembled big-endian, so offset 0 is the most significant byte. Field positions within the entry: server is offset bytes 0..1, the generation is bits 2:1 of byte 4, P is bit 0 of byte 4, Q is bit 0 of byte 5, and priority is byte 7.
- R6: With `trig_force` high, the stored P and Q bits are ignored and the state is treated as 00.
- R7: The state is {P,Q}. State 00 with priority 0xFF sets Q (`done_code` 1). State 00 with any other priority sets P and presents the interrupt (`done_code` 0). State 10 sets Q (`done_code` 1). States 01 and 11 drop the trigger without any write (`done_code` 2).
- R8: Setting P writes one byte at entry address + 4 with the value 1 | (generation << 1). Setting Q writes one byte at entry address + 5 with the value 1. Every other byte of the entry is left unchanged.
- R9: `pres_valid` is high for exactly the `done` cycle of an outcome with `done_code` 0. In that cycle `pres_server` is the server field shifted right by 2, `pres_src` is `src_offset` + source, and `pres_prio` is the priority.
- R10: A memory error on the read ends the trigger with no write. A memory error on the write ends it with no presentation. Both end with `done_code` 4.
- R11: A trigger is accepted only while `busy` is low, and triggers offered while busy are ignored. Each accepted trigger yields exactly one single-cycle `done` pulse carrying its `done_code`.
- R12: `mem_req` stays high, with a stable address, direction and write data, until `mem_ack`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| trig_valid | input | 1 | Trigger request |
| trig_src | input | SRC_W | Local source number of the trigger |
| trig_force | input | 1 | Ignore stored P/Q (replay) |
| busy | output | 1 | A trigger is in progress |
| done | output | 1 | One-cycle completion pulse |
| done_code | output | 3 | 0 sent, 1 Q set, 2 dropped, 3 rejected, 4 memory error |
| tbl_base | input | AW | Table base address (low 4 bits ignored) |
| tbl_en | input | 1 | Table enable |
| tbl_len | input | SRC_W+1 | Number of valid sources |
| big_entry | input | 1 | 128-byte entry stride when set, else 16 |
| src_offset | input | IRQ_W | Offset added to the source for the presenter |
| mem_req | output | 1 | Memory request, held until acknowledge |
| mem_we | output | 1 | 1 byte write, 0 eight-byte read |
| mem_addr | output | AW | Memory byte address |
| mem_wdata | output | 8 | Write byte |
| mem_ack | input | 1 | Memory acknowledge |
| mem_err | input | 1 | Error response, valid with acknowledge |
| mem_rdata | input | 64 | Read data, lane k is byte at address + k |
| pres_valid | output | 1 | Interrupt presentation strobe |
| pres_server | output | 14 | Target server |
| pres_src | output | IRQ_W | Global source number |
| pres_prio | output | 8 | Priority |

## Verification
A wrong decision, a wrong field position or a wrong entry address shows at the ports within one trigger, about five cycles. It appears as a wrong `done_code`, a write to the wrong byte, a changed byte that should be untouched, or a presenter value that does not match the entry. A wrong busy or state register shows as a missing or doubled `done`, a memory request outside a trigger, or a trigger taken while busy, which would alter a second entry. The sweep covers every P/Q state, both priority classes, every generation, both strides and the force input. Separate cases cover the bounds edge, a disabled table, and an error on each memory phase.

// File: rtl/msi_pq_pkg.sv
package msi_pq_pkg;

  localparam int unsigned ENTRY_BYTES = 8;
  localparam int unsigned SRV_W       = 16;
  localparam int unsigned SRV_OUT_W   = SRV_W - 2;
  localparam int unsigned PRIO_W      = 8;
  localparam int unsigned GEN_W       = 2;
  localparam int unsigned P_BYTE_OFS  = 4;
  localparam int unsigned Q_BYTE_OFS  = 5;
  localparam int unsigned SMALL_SHIFT = 4;
  localparam int unsigned BIG_SHIFT   = 7;
  localparam logic [PRIO_W-1:0] PRIO_MASKED = 8'hFF;

  // bit positions within the assembled big-endian entry value
  localparam int unsigned SRV_LSB  = 48;
  localparam int unsigned GEN_LSB  = 25;
  localparam int unsigned P_BIT    = 24;
  localparam int unsigned Q_BIT    = 16;
  localparam int unsigned PRIO_LSB = 0;

  typedef enum logic [2:0] {
    CODE_SENT   = 3'd0,
    CODE_QSET   = 3'd1,
    CODE_DROP   = 3'd2,
    CODE_REJECT = 3'd3,
    CODE_MEMERR = 3'd4
  } done_code_e;

  typedef enum logic [1:0] {
    ACT_SEND = 2'd0,
    ACT_SETQ = 2'd1,
    ACT_DROP = 2'd2
  } action_e;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_READ = 2'd1,
    ST_WRITE = 2'd2,
    ST_DONE = 2'd3
  } disp_state_e;

  typedef struct packed {
    logic [SRV_W-1:0]  server;
    logic [PRIO_W-1:0] prio;
    logic [GEN_W-1:0]  gen;
    logic              p;
    logic              q;
  } entry_fields_t;

endpackage

// File: rtl/msi_ive_addr.sv
module msi_ive_addr
  import msi_pq_pkg::*;
#(
  parameter int unsigned AW    = 32,
  parameter int unsigned SRC_W = 11
) (
  input  logic [AW-1:0]  base,
  input  logic           enable,
  input  logic [SRC_W:0] length,
  input  logic           big,
  input  logic [SRC_W-1:0] src,
  output logic [AW-1:0]  entry_addr,
  output logic           in_range
);

  localparam int unsigned ALIGN = SMALL_SHIFT;

  logic [AW-1:0] base_aligned;
  logic [AW-1:0] src_ext;
  logic [AW-1:0] stride_ofs;

  always_comb begin
    base_aligned = {base[AW-1:ALIGN], {ALIGN{1'b0}}};
    src_ext      = AW'(src);
    stride_ofs   = big ? (src_ext << BIG_SHIFT) : (src_ext << SMALL_SHIFT);
    entry_addr   = base_aligned + stride_ofs;
    in_range     = enable && ({1'b0, src} < length);
  end

endmodule

// File: rtl/msi_ive_decode.sv
module msi_ive_decode
  import msi_pq_pkg::*;
(
  input  logic [8*ENTRY_BYTES-1:0] lanes,
  output entry_fields_t            fields
);

  logic [8*ENTRY_BYTES-1:0] value;

  // lane k holds the byte at entry offset k; offset 0 is most significant
  for (genvar k = 0; k < ENTRY_BYTES; k++) begin : g_swap
    assign value[8*(ENTRY_BYTES-1-k) +: 8] = lanes[8*k +: 8];
  end

  always_comb begin
    fields.server = value[SRV_LSB +: SRV_W];
    fields.prio   = value[PRIO_LSB +: PRIO_W];
    fields.gen    = value[GEN_LSB +: GEN_W];
    fields.p      = value[P_BIT];
    fields.q      = value[Q_BIT];
  end

endmodule

// File: rtl/msi_pq_decide.sv
module msi_pq_decide
  import msi_pq_pkg::*;
(
  input  entry_fields_t fields,
  input  logic          force_idle,
  output action_e       action
);

  logic [1:0] pq;

  always_comb begin
    pq = force_idle ? 2'b00 : {fields.p, fields.q};
    unique case (pq)
      2'b00:   action = (fields.prio == PRIO_MASKED) ? ACT_SETQ : ACT_SEND;
      2'b10:   action = ACT_SETQ;
      default: action = ACT_DROP;
    endcase
  end

endmodule

// File: rtl/msi_pq_dispatch.sv
module msi_pq_dispatch
  import msi_pq_pkg::*;
#(
  parameter int unsigned AW    = 32,
  parameter int unsigned SRC_W = 11,
  parameter int unsigned IRQ_W = 20
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              trig_valid,
  input  logic [SRC_W-1:0]  trig_src,
  input  logic              trig_force,
  output logic              busy,
  output logic              done,
  output logic [2:0]        done_code,
  input  logic [AW-1:0]     tbl_base,
  input  logic              tbl_en,
  input  logic [SRC_W:0]    tbl_len,
  input  logic              big_entry,
  input  logic [IRQ_W-1:0]  src_offset,
  output logic              mem_req,
  output logic              mem_we,
  output logic [AW-1:0]     mem_addr,
  output logic [7:0]        mem_wdata,
  input  logic              mem_ack,
  input  logic              mem_err,
  input  logic [63:0]       mem_rdata,
  output logic              pres_valid,
  output logic [13:0]       pres_server,
  output logic [IRQ_W-1:0]  pres_src,
  output logic [7:0]        pres_prio
);

  disp_state_e   state_q, state_d;
  logic [AW-1:0] addr_q, addr_d;
  logic [7:0]    wdata_q, wdata_d;
  done_code_e    code_q, code_d;
  logic [SRC_W-1:0] src_q;
  logic          force_q;
  logic [SRV_W-1:0]  server_q;
  logic [PRIO_W-1:0] prio_q;
  logic          load_trig;
  logic          load_entry;
  logic          step_en;

  logic [AW-1:0] ent_addr;
  logic          ent_ok;
  entry_fields_t dec;
  action_e       act;

  msi_ive_addr #(.AW(AW), .SRC_W(SRC_W)) u_addr (
    .base       (tbl_base),
    .enable     (tbl_en),
    .length     (tbl_len),
    .big        (big_entry),
    .src        (trig_src),
    .entry_addr (ent_addr),
    .in_range   (ent_ok)
  );

  msi_ive_decode u_decode (
    .lanes  (mem_rdata),
    .fields (dec)
  );

  msi_pq_decide u_decide (
    .fields     (dec),
    .force_idle (force_q),
    .action     (act)
  );

  // next-state process
  always_comb begin
    state_d    = state_q;
    addr_d     = addr_q;
    wdata_d    = wdata_q;
    code_d     = code_q;
    load_trig  = 1'b0;
    load_entry = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        if (trig_valid) begin
          load_trig = 1'b1;
          if (ent_ok) begin
            addr_d  = ent_addr;
            state_d = ST_READ;
          end else begin
            code_d  = CODE_REJECT;
            state_d = ST_DONE;
          end
        end
      end
      ST_READ: begin
        if (mem_ack) begin
          if (mem_err) begin
            code_d  = CODE_MEMERR;
            state_d = ST_DONE;
          end else begin
            load_entry = 1'b1;
            unique case (act)
              ACT_SEND: begin
                addr_d  = addr_q + AW'(P_BYTE_OFS);
                wdata_d = {{(8-GEN_W-1){1'b0}}, dec.gen, 1'b1};
                code_d  = CODE_SENT;
                state_d = ST_WRITE;
              end
              ACT_SETQ: begin
                addr_d  = addr_q + AW'(Q_BYTE_OFS);
                wdata_d = 8'h01;
                code_d  = CODE_QSET;
                state_d = ST_WRITE;
              end
              default: begin
                code_d  = CODE_DROP;
                state_d = ST_DONE;
              end
            endcase
          end
        end
      end
      ST_WRITE: begin
        if (mem_ack) begin
          if (mem_err) code_d = CODE_MEMERR;
          state_d = ST_DONE;
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  assign step_en = (state_d != state_q);

  // register process
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      addr_q  <= '0;
      wdata_q <= '0;
      code_q  <= CODE_SENT;
    end else begin
      state_q <= state_d;
      if (step_en) begin
        addr_q  <= addr_d;
        wdata_q <= wdata_d;
        code_q  <= code_d;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      src_q   <= '0;
      force_q <= 1'b0;
    end else if (load_trig) begin
      src_q   <= trig_src;
      force_q <= trig_force;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      server_q <= '0;
      prio_q   <= '0;
    end else if (load_entry) begin
      server_q <= dec.server;
      prio_q   <= dec.prio;
    end
  end

  assign busy        = (state_q != ST_IDLE);
  assign mem_req     = (state_q == ST_READ) || (state_q == ST_WRITE);
  assign mem_we      = (state_q == ST_WRITE);
  assign mem_addr    = addr_q;
  assign mem_wdata   = wdata_q;
  assign done        = (state_q == ST_DONE);
  assign done_code   = code_q;
  assign pres_valid  = (state_q == ST_DONE) && (code_q == CODE_SENT);
  assign pres_server = server_q[SRV_W-1:2];
  assign pres_src    = src_offset + IRQ_W'(src_q);
  assign pres_prio   = prio_q;

endmodule

// File: rtl/msi_pq_dispatch_chk.sv
module msi_pq_dispatch_chk #(
  parameter int unsigned AW = 32
) (
  input logic          clk,
  input logic          rst_n,
  input logic          busy,
  input logic          done,
  input logic [2:0]    done_code,
  input logic          mem_req,
  input logic          mem_we,
  input logic [AW-1:0] mem_addr,
  input logic [7:0]    mem_wdata,
  input logic          mem_ack,
  input logic          pres_valid,
  input logic [7:0]    pres_prio
);

  AST_IDLE_NO_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !mem_req) else $error("idle request"); // R11

  AST_REQ_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr) && $stable(mem_we) && $stable(mem_wdata)))
    else $error("request dropped"); // R12

  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done) else $error("done too long"); // R11

  AST_PRES_ONLY_SENT: assert property (@(posedge clk) disable iff (!rst_n)
    pres_valid |-> (done && done_code == 3'd0)) else $error("stray present"); // R9

  AST_SENT_PRESENTS: assert property (@(posedge clk) disable iff (!rst_n)
    (done && done_code == 3'd0) |-> pres_valid) else $error("missing present"); // R9

  AST_MASK_NOT_SENT: assert property (@(posedge clk) disable iff (!rst_n)
    pres_valid |-> (pres_prio != 8'hFF)) else $error("masked sent"); // R7

  AST_WRITE_BYTE_POS: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && mem_we) |-> (mem_addr[3:0] == 4'd4 || mem_addr[3:0] == 4'd5))
    else $error("write offset"); // R8

  AST_Q_VALUE: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && mem_we && mem_addr[3:0] == 4'd5) |-> (mem_wdata == 8'h01))
    else $error("Q value"); // R8

  AST_P_VALUE: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && mem_we && mem_addr[3:0] == 4'd4) |-> (mem_wdata[0] && mem_wdata[7:3] == 5'd0))
    else $error("P value"); // R8

endmodule

bind msi_pq_dispatch msi_pq_dispatch_chk #(.AW(AW)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .busy       (busy),
  .done       (done),
  .done_code  (done_code),
  .mem_req    (mem_req),
  .mem_we     (mem_we),
  .mem_addr   (mem_addr),
  .mem_wdata  (mem_wdata),
  .mem_ack    (mem_ack),
  .pres_valid (pres_valid),
  .pres_prio  (pres_prio)
);

// File: tb/msi_pq_dispatch_tb.sv
`timescale 1ns/1ps
module msi_pq_dispatch_tb;

  localparam int AW = 16;
  localparam int SRC_W = 4;
  localparam int IRQ_W = 12;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic trig_valid = 1'b0;
  logic [SRC_W-1:0] trig_src = '0;
  logic trig_force = 1'b0;
  logic busy, done;
  logic [2:0] done_code;
  logic [AW-1:0] tbl_base = 16'h0105;
  logic tbl_en = 1'b1;
  logic [SRC_W:0] tbl_len = 5'd16;
  logic big_entry = 1'b0;
  logic [IRQ_W-1:0] src_offset = 12'h300;
  logic mem_req, mem_we;
  logic [AW-1:0] mem_addr;
  logic [7:0] mem_wdata;
  logic mem_ack, mem_err;
  logic [63:0] mem_rdata;
  logic pres_valid;
  logic [13:0] pres_server;
  logic [IRQ_W-1:0] pres_src;
  logic [7:0] pres_prio;

  logic [7:0] mem [0:4095];
  int txn_count = 0;
  int done_count = 0;
  logic err_rd = 1'b0;
  logic err_wr = 1'b0;
  logic [AW-1:0] last_rd_addr = '0;
  int checks = 0;
  int fails = 0;

  logic [2:0] got_code;
  logic got_pv;
  logic [13:0] got_srv;
  logic [IRQ_W-1:0] got_src;
  logic [7:0] got_prio;

  always #10 clk = ~clk;

  msi_pq_dispatch #(.AW(AW), .SRC_W(SRC_W), .IRQ_W(IRQ_W)) u_dut (
    .clk(clk), .rst_n(rst_n), .trig_valid(trig_valid), .trig_src(trig_src),
    .trig_force(trig_force), .busy(busy), .done(done), .done_code(done_code),
    .tbl_base(tbl_base), .tbl_en(tbl_en), .tbl_len(tbl_len), .big_entry(big_entry),
    .src_offset(src_offset), .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .mem_ack(mem_ack), .mem_err(mem_err), .mem_rdata(mem_rdata),
    .pres_valid(pres_valid), .pres_server(pres_server), .pres_src(pres_src),
    .pres_prio(pres_prio)
  );

  // memory model: acknowledge one cycle after a request is seen
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mem_ack <= 1'b0;
      mem_err <= 1'b0;
      mem_rdata <= '0;
    end else if (mem_req && !mem_ack) begin
      mem_ack <= 1'b1;
      txn_count = txn_count + 1;
      if (mem_we) begin
        mem_err <= err_wr;
        if (!err_wr) mem[mem_addr[11:0]] = mem_wdata;
      end else begin
        mem_err <= err_rd;
        last_rd_addr = mem_addr;
        for (int k = 0; k < 8; k++) mem_rdata[8*k +: 8] <= mem[mem_addr[11:0] + 12'(k)];
      end
    end else begin
      mem_ack <= 1'b0;
      mem_err <= 1'b0;
    end
  end

  always @(posedge clk) if (rst_n && done) done_count = done_count + 1;

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [AW-1:0] ent(input int s);
    return 16'h0100 + 16'(s * (big_entry ? 128 : 16));
  endfunction

  task automatic put_entry(input int s, input logic [15:0] srv, input logic p, input logic q,
                           input logic [1:0] gen, input logic [7:0] prio);
    logic [AW-1:0] a;
    a = ent(s);
    mem[a[11:0]]       = srv[15:8];
    mem[a[11:0] + 1]   = srv[7:0];
    mem[a[11:0] + 2]   = 8'hA5;
    mem[a[11:0] + 3]   = 8'h5A;
    mem[a[11:0] + 4]   = {5'd0, gen, p};
    mem[a[11:0] + 5]   = {7'd0, q};
    mem[a[11:0] + 6]   = 8'hC3;
    mem[a[11:0] + 7]   = prio;
  endtask

  task automatic run_trig(input int s, input logic frc);
    @(negedge clk);
    txn_count = 0;
    trig_valid = 1'b1;
    trig_src = SRC_W'(s);
    trig_force = frc;
    @(negedge clk);
    trig_valid = 1'b0;
    trig_force = 1'b0;
    got_code = 3'd7;
    got_pv = 1'b0;
    for (int w = 0; w < 40; w++) begin
      if (done) begin
        got_code = done_code;
        got_pv = pres_valid;
        got_srv = pres_server;
        got_src = pres_src;
        got_prio = pres_prio;
        break;
      end
      @(negedge clk);
    end
    @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    for (int i = 0; i < 4096; i++) mem[i] = 8'h00;
    #5;
    check("R1 busy", {31'd0, busy}, 0);
    check("R1 done", {31'd0, done}, 0);
    check("R1 mem_req", {31'd0, mem_req}, 0);
    check("R1 pres_valid", {31'd0, pres_valid}, 0);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R5 R6 R7 R8 R9 R4 sweep
    for (int b = 0; b < 2; b++) begin
      for (int f = 0; f < 2; f++) begin
        for (int st = 0; st < 4; st++) begin
          for (int m = 0; m < 2; m++) begin
            for (int g = 0; g < 4; g++) begin
              int s, pq, exp_code, exp_txn;
              logic [15:0] srv;
              logic [7:0] prio, b4, b5, e4, e5;
              logic [AW-1:0] a;
              big_entry = b[0];
              s = (b * 7 + f * 5 + st * 3 + m * 11 + g) % 16;
              srv = 16'(16'h1234 + s * 16'h0137 + st);
              prio = m ? 8'hFF : 8'(8'h10 + g * 4 + st);
              put_entry(s, srv, st[1], st[0], g[1:0], prio);
              a = ent(s);
              b4 = mem[a[11:0] + 4];
              b5 = mem[a[11:0] + 5];
              pq = f ? 0 : st;
              if (pq == 0) exp_code = (prio == 8'hFF) ? 1 : 0;
              else if (pq == 2) exp_code = 1;
              else exp_code = 2;
              exp_txn = (exp_code == 2) ? 1 : 2;
              e4 = (exp_code == 0) ? {5'd0, g[1:0], 1'b1} : b4;
              e5 = (exp_code == 1) ? 8'h01 : b5;
              run_trig(s, f[0]);
              check("R7 code", {29'd0, got_code}, exp_code);
              check("R4 read addr", {16'd0, last_rd_addr}, {16'd0, a});
              check("R8 txn count", txn_count, exp_txn);
              check("R8 P byte", {24'd0, mem[a[11:0] + 4]}, {24'd0, e4});
              check("R8 Q byte", {24'd0, mem[a[11:0] + 5]}, {24'd0, e5});
              check("R8 other bytes", {mem[a[11:0]], mem[a[11:0]+2], mem[a[11:0]+6], mem[a[11:0]+7]},
                    {srv[15:8], 8'hA5, 8'hC3, prio});
              check("R9 pres_valid", {31'd0, got_pv}, (exp_code == 0) ? 1 : 0);
              if (exp_code == 0) begin
                check("R9 R5 server", {18'd0, got_srv}, {18'd0, srv[15:2]});
                check("R9 source", {20'd0, got_src}, 32'h300 + s);
                check("R9 R5 prio", {24'd0, got_prio}, {24'd0, prio});
              end
            end
          end
        end
      end
    end
    big_entry = 1'b0;

    // R3 bounds edge
    tbl_len = 5'd10;
    put_entry(9, 16'h0040, 1'b0, 1'b0, 2'd1, 8'h05);
    run_trig(9, 1'b0);
    check("R3 last valid source", {29'd0, got_code}, 0);
    put_entry(10, 16'h0040, 1'b0, 1'b0, 2'd1, 8'h05);
    run_trig(10, 1'b0);
    check("R3 source==len rejected", {29'd0, got_code}, 3);
    check("R3 no request", txn_count, 0);
    check("R3 entry untouched", {24'd0, mem[ent(10) + 4]}, 32'h02);
    run_trig(15, 1'b0);
    check("R3 high source rejected", {29'd0, got_code}, 3);
    tbl_len = 5'd0;
    run_trig(0, 1'b0);
    check("R3 empty table", {29'd0, got_code}, 3);
    tbl_len = 5'd16;

    // R2 disabled table
    tbl_en = 1'b0;
    put_entry(3, 16'h0100, 1'b0, 1'b0, 2'd0, 8'h07);
    run_trig(3, 1'b0);
    check("R2 rejected", {29'd0, got_code}, 3);
    check("R2 no request", txn_count, 0);
    check("R2 no present", {31'd0, got_pv}, 0);
    tbl_en = 1'b1;

    // R10 read error
    err_rd = 1'b1;
    put_entry(4, 16'h0200, 1'b0, 1'b0, 2'd2, 8'h07);
    run_trig(4, 1'b0);
    err_rd = 1'b0;
    check("R10 read error code", {29'd0, got_code}, 4);
    check("R10 no write after read error", txn_count, 1);
    check("R10 P unchanged", {24'd0, mem[ent(4) + 4]}, 32'h04);
    check("R10 no present", {31'd0, got_pv}, 0);

    // R10 write error
    err_wr = 1'b1;
    run_trig(4, 1'b0);
    err_wr = 1'b0;
    check("R10 write error code", {29'd0, got_code}, 4);
    check("R10 write error no present", {31'd0, got_pv}, 0);
    check("R10 write discarded", {24'd0, mem[ent(4) + 4]}, 32'h04);

    // R11 trigger while busy is ignored
    put_entry(5, 16'h0300, 1'b0, 1'b0, 2'd0, 8'h09);
    put_entry(6, 16'h0300, 1'b0, 1'b0, 2'd0, 8'h09);
    done_count = 0;
    @(negedge clk);
    txn_count = 0;
    trig_valid = 1'b1; trig_src = 4'd5;
    @(negedge clk);
    trig_src = 4'd6;
    @(negedge clk);
    @(negedge clk);
    trig_valid = 1'b0;
    repeat (12) @(negedge clk);
    check("R11 single done", done_count, 1);
    check("R11 busy source served", {24'd0, mem[ent(5) + 4]}, 32'h01);
    check("R11 busy trigger ignored", {24'd0, mem[ent(6) + 4]}, 32'h00);
    check("R11 txn count", txn_count, 2);
    check("R11 idle after", {31'd0, busy}, 0);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

endmodule